// File: doc/BRIEF.md
# Parallel Link Host Sequencer

This block is the host side of an 8-bit byte-wide parallel link of the enhanced parallel port kind. It runs one transfer at a time toward a peripheral. A transfer is an address write, a data write, an address read or a data read. Each transfer is a four-phase handshake. The host drives the bus and the direction line and lets them settle. It then pulls one of two active-low strobes. The peripheral answers by raising its wait line, and the host releases the strobe. The peripheral then drops wait, which closes the transfer. All timing is counted in clock cycles set by parameters. A bounded timeout ends any transfer whose peripheral stops answering.

On the user side a one-cycle request carries the operation code and the byte to write. The block raises a busy flag while the transfer runs. It ends a good transfer with a one-cycle done pulse, and for reads the captured byte is presented on the read-data output. A transfer that times out instead sets a sticky error flag. The link inputs (wait and the incoming bus) are asynchronous to the clock, so each passes through a two-flop synchroniser before use.

Top module: `pport_host_ctrl`

## Requirements
- R1: During and after reset both strobes are high, the direction line is high (read), the bus output enable is low, and busy, done and error are low.
- R2: A request (req_valid high at a clock edge) is taken only while the block is idle. A request made during a transfer has no effect on the link outputs or on the transfer in progress.
- R3: req_op bit 0 picks the strobe: 0 selects the address strobe and 1 the data strobe. The strobe that is not selected stays high for the whole transfer, so the two strobes are never low together.
- R4: The bus value, the direction and the output enable are set at the edge that takes the request. The selected strobe goes low SETUP_CYC edges later.
- R5: The strobe stays low for at least STROBE_CYC cycles. It is released at the first edge after that minimum where the synchronised wait is high. That synchronised value is the wait input sampled two edges earlier.
- R6: For a write (req_op bit 1 = 0) the direction line is low and the output enable is high. The bus carries the request byte from the accepting edge until HOLD_CYC edges after the strobe is released.
- R7: For a read (req_op bit 1 = 1) the direction line stays high and the output enable stays low. The read data is the bus input value present two clock edges before the strobe-release edge, and it is held until the next read.
- R8: After the strobe is released, the first edge (no earlier than HOLD_CYC+1 edges after release) at which synchronised wait is low starts a done pulse. That pulse lasts exactly one cycle. Busy is high from the accepting edge through the done cycle and low one edge later.
- R9: If synchronised wait is not high by TIMEOUT_CYC edges after the strobe went low, the strobe is released at that edge. The bus is then freed, the error flag rises, busy falls and no done pulse is given.
- R10: If synchronised wait is not low by TIMEOUT_CYC edges after the strobe was released, the same abort happens at that edge.
- R11: The error flag stays high while idle and clears at the edge that takes the next request. It is never high together with busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start strobe for one transfer |
| req_op | input | 2 | Bit 1: 1 = read, 0 = write; bit 0: 1 = data strobe, 0 = address strobe |
| req_wdata | input | 8 | Byte to send on a write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a good transfer |
| rd_data | output | 8 | Byte captured by the last read |
| err | output | 1 | Sticky timeout flag |
| addr_stb_n | output | 1 | Address strobe, active low |
| data_stb_n | output | 1 | Data strobe, active low |
| link_rd | output | 1 | Direction: 1 = host reads, 0 = host writes |
| link_dout | output | 8 | Bus value driven by the host |
| link_doe | output | 1 | Bus output enable |
| link_din | input | 8 | Bus value seen by the host |
| link_wait | input | 1 | Peripheral wait handshake |

## Verification
The bench numbers its edges from the one that takes the request. From that edge, the peripheral answer delays and the parameters give all later times. The strobe falls at edge SETUP_CYC. The release comes at the later of STROBE_CYC+1 and the wait-rise delay plus two. The done pulse follows release after the later of HOLD_CYC+1 and the wait-fall delay plus two edges. A timeout lands at exactly TIMEOUT_CYC edges after the phase that began it. Every output is compared at the falling clock edge after each rising edge against these computed times. Some runs put the wait delays just inside and just outside the timeout. One run changes the read bus two edges before release, which pins down the capture cycle to one exact edge.

// File: rtl/pph_pkg.sv
package pph_pkg;

  // bit positions inside the request operation code
  localparam int OP_DATA_BIT = 0;  // 1: data strobe, 0: address strobe
  localparam int OP_READ_BIT = 1;  // 1: host reads, 0: host writes

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_WAIT_HI,
    ST_RELEASE,
    ST_WAIT_LO,
    ST_DONE
  } pph_state_e;

  function automatic int pph_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pph_sync.sv
// Two-flop synchroniser, one chain per bit.
module pph_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic sync_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= din[i];
        sync_q <= meta_q;
      end
    end
    assign dout[i] = sync_q;
  end

endmodule

// File: rtl/pph_timer.sv
// Loadable down counter; counts to zero and stops there.
module pph_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/pph_seq.sv
// Transfer sequencer: state machine with registered link and user outputs.
module pph_seq
  import pph_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 4,
  parameter int STROBE_CYC = 8,
  parameter int HOLD_CYC   = 2,
  parameter int PH_W       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              wait_s,
  input  logic [DATA_W-1:0] bus_s,
  input  logic              ph_zero,
  input  logic              to_zero,
  output logic              ph_load,
  output logic [PH_W-1:0]   ph_val,
  output logic              to_load,
  output logic              addr_stb_n,
  output logic              data_stb_n,
  output logic              link_rd,
  output logic [DATA_W-1:0] link_dout,
  output logic              link_doe,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              err
);

  pph_state_e state_q;
  logic [1:0] op_q;

  // timer reloads, decided from the current state and inputs
  always_comb begin
    ph_load = 1'b0;
    ph_val  = PH_W'(SETUP_CYC - 1);
    to_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ph_load = 1'b1;
          ph_val  = PH_W'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (ph_zero) begin
          ph_load = 1'b1;
          ph_val  = PH_W'(STROBE_CYC - 1);
          to_load = 1'b1;
        end
      end
      ST_WAIT_HI: begin
        if (wait_s) begin
          ph_load = 1'b1;
          ph_val  = PH_W'(HOLD_CYC - 1);
          to_load = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      op_q       <= 2'b00;
      addr_stb_n <= 1'b1;
      data_stb_n <= 1'b1;
      link_rd    <= 1'b1;
      link_doe   <= 1'b0;
      link_dout  <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      rd_data    <= '0;
      err        <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          done <= 1'b0;
          if (req_valid) begin
            op_q      <= req_op;
            link_dout <= req_wdata;
            link_rd   <= req_op[OP_READ_BIT];
            link_doe  <= ~req_op[OP_READ_BIT];
            busy      <= 1'b1;
            err       <= 1'b0;
            state_q   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (ph_zero) begin
            if (op_q[OP_DATA_BIT]) begin
              data_stb_n <= 1'b0;
            end else begin
              addr_stb_n <= 1'b0;
            end
            state_q <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          if (ph_zero) begin
            state_q <= ST_WAIT_HI;
          end
        end
        ST_WAIT_HI: begin
          if (wait_s) begin
            addr_stb_n <= 1'b1;
            data_stb_n <= 1'b1;
            if (op_q[OP_READ_BIT]) begin
              rd_data <= bus_s;
            end
            state_q <= ST_RELEASE;
          end else if (to_zero) begin
            addr_stb_n <= 1'b1;
            data_stb_n <= 1'b1;
            link_rd    <= 1'b1;
            link_doe   <= 1'b0;
            busy       <= 1'b0;
            err        <= 1'b1;
            state_q    <= ST_IDLE;
          end
        end
        ST_RELEASE: begin
          if (ph_zero) begin
            link_rd  <= 1'b1;
            link_doe <= 1'b0;
            state_q  <= ST_WAIT_LO;
          end
        end
        ST_WAIT_LO: begin
          if (!wait_s) begin
            done    <= 1'b1;
            state_q <= ST_DONE;
          end else if (to_zero) begin
            busy    <= 1'b0;
            err     <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_DONE: begin
          done    <= 1'b0;
          busy    <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pport_host_ctrl.sv
// Host-side sequencer for a byte-wide four-phase parallel link.
module pport_host_ctrl
  import pph_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SETUP_CYC   = 4,        // bus valid before strobe
  parameter int STROBE_CYC  = 8,        // minimum strobe low time
  parameter int HOLD_CYC    = 2,        // bus hold after strobe release
  parameter int TIMEOUT_CYC = 1000000   // wait response bound, per phase
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              err,
  output logic              addr_stb_n,
  output logic              data_stb_n,
  output logic              link_rd,
  output logic [DATA_W-1:0] link_dout,
  output logic              link_doe,
  input  logic [DATA_W-1:0] link_din,
  input  logic              link_wait
);

  localparam int PH_MAX = pph_max3(SETUP_CYC, STROBE_CYC, HOLD_CYC);
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int TO_W   = $clog2(TIMEOUT_CYC + 1);

  logic              wait_s;
  logic [DATA_W-1:0] bus_s;
  logic              ph_load;
  logic [PH_W-1:0]   ph_val;
  logic              ph_zero;
  logic              to_load;
  logic              to_zero;

  pph_sync #(.W(1)) u_wait_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (link_wait),
    .dout (wait_s)
  );

  pph_sync #(.W(DATA_W)) u_bus_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (link_din),
    .dout (bus_s)
  );

  pph_timer #(.W(PH_W)) u_phase_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (ph_load),
    .load_val (ph_val),
    .zero     (ph_zero)
  );

  pph_timer #(.W(TO_W)) u_timeout_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (to_load),
    .load_val (TO_W'(TIMEOUT_CYC - 1)),
    .zero     (to_zero)
  );

  pph_seq #(
    .DATA_W     (DATA_W),
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .PH_W       (PH_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_wdata  (req_wdata),
    .wait_s     (wait_s),
    .bus_s      (bus_s),
    .ph_zero    (ph_zero),
    .to_zero    (to_zero),
    .ph_load    (ph_load),
    .ph_val     (ph_val),
    .to_load    (to_load),
    .addr_stb_n (addr_stb_n),
    .data_stb_n (data_stb_n),
    .link_rd    (link_rd),
    .link_dout  (link_dout),
    .link_doe   (link_doe),
    .busy       (busy),
    .done       (done),
    .rd_data    (rd_data),
    .err        (err)
  );

endmodule

// File: rtl/pph_checker.sv
module pph_checker #(
  parameter int STROBE_CYC = 8
) (
  input logic clk,
  input logic rst,
  input logic addr_stb_n,
  input logic data_stb_n,
  input logic link_rd,
  input logic link_doe,
  input logic busy,
  input logic done,
  input logic err
);

  logic        any_low;
  logic [31:0] low_cnt;

  assign any_low = !addr_stb_n || !data_stb_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
    end else if (any_low) begin
      if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
    end else begin
      low_cnt <= '0;
    end
  end

  // R1: reset leaves the link idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (addr_stb_n && data_stb_n && link_rd && !link_doe && !busy && !done));

  // R3: never both strobes at once
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!addr_stb_n && !data_stb_n));

  // R5: a released strobe was low for at least the minimum width
  a_r5_min_width: assert property (@(posedge clk) disable iff (rst)
    ($past(any_low) && !any_low) |-> (low_cnt >= 32'(STROBE_CYC)));

  // R6: a write strobe always has the bus driven
  a_r6_drive_on_write: assert property (@(posedge clk) disable iff (rst)
    (any_low && !link_rd) |-> link_doe);

  // R7: a read strobe never has the bus driven
  a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    (any_low && link_rd) |-> !link_doe);

  // R8: done lasts one cycle and only while busy
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_while_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  // R11: error and busy exclude each other
  a_r11_err_not_busy: assert property (@(posedge clk) disable iff (rst)
    !(err && busy));

endmodule

bind pport_host_ctrl pph_checker #(.STROBE_CYC(STROBE_CYC)) u_pph_checker (
  .clk        (clk),
  .rst        (rst),
  .addr_stb_n (addr_stb_n),
  .data_stb_n (data_stb_n),
  .link_rd    (link_rd),
  .link_doe   (link_doe),
  .busy       (busy),
  .done       (done),
  .err        (err)
);

// File: tb/test_pport_host_ctrl.sv
module test_pport_host_ctrl;

  localparam int SETUP = 4;
  localparam int STB   = 8;
  localparam int HOLD  = 2;
  localparam int TMO   = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [7:0] req_wdata = 8'h00;
  logic       busy, done, err;
  logic [7:0] rd_data;
  logic       addr_stb_n, data_stb_n, link_rd, link_doe;
  logic [7:0] link_dout;
  logic [7:0] link_din = 8'h00;
  logic       link_wait = 1'b0;

  int checks = 0;
  int errors = 0;

  // peripheral answer delays, in cycles
  int da = 1;
  int dr = 1;
  int lo_cnt = 0;
  int hi_cnt = 0;

  always #2 clk = ~clk;

  pport_host_ctrl #(
    .DATA_W      (8),
    .SETUP_CYC   (SETUP),
    .STROBE_CYC  (STB),
    .HOLD_CYC    (HOLD),
    .TIMEOUT_CYC (TMO)
  ) i_pport_host_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_wdata  (req_wdata),
    .busy       (busy),
    .done       (done),
    .rd_data    (rd_data),
    .err        (err),
    .addr_stb_n (addr_stb_n),
    .data_stb_n (data_stb_n),
    .link_rd    (link_rd),
    .link_dout  (link_dout),
    .link_doe   (link_doe),
    .link_din   (link_din),
    .link_wait  (link_wait)
  );

  // behavioural peripheral: wait rises da cycles into a strobe,
  // falls dr cycles after the strobe is gone
  always @(negedge clk) begin
    if (rst) begin
      link_wait <= 1'b0;
      lo_cnt = 0;
      hi_cnt = 0;
    end else if (!addr_stb_n || !data_stb_n) begin
      lo_cnt = lo_cnt + 1;
      hi_cnt = 0;
      if (lo_cnt >= da) link_wait <= 1'b1;
    end else begin
      lo_cnt = 0;
      if (link_wait) begin
        hi_cnt = hi_cnt + 1;
        if (hi_cnt >= dr) link_wait <= 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h time=%0t", tag, what, act, exp, $time);
    end
  endtask

  // one transfer, compared against the computed timeline on every clock
  task automatic run_op(input logic [1:0] op, input logic [7:0] wd, input logic [7:0] rv,
                        input int d_a, input int d_r, input bit stray);
    bit rd   = op[1];
    bit seld = op[0];
    int s    = SETUP;
    int r    = 0;
    int l    = 0;
    int t    = 0;
    bit to1  = 0;
    bit to2  = 0;
    int endk;
    int drv_end;
    da = d_a;
    dr = d_r;
    link_din = rv;
    if (d_a + 2 > TMO) begin
      to1 = 1;
      t   = s + TMO;
    end else begin
      r = (s + STB + 1 > s + d_a + 2) ? s + STB + 1 : s + d_a + 2;
      if (d_r + 2 > TMO) begin
        to2 = 1;
        t   = r + TMO;
      end else begin
        l = (r + HOLD + 1 > r + d_r + 2) ? r + HOLD + 1 : r + d_r + 2;
      end
    end
    endk    = (to1 || to2) ? t : l + 1;
    drv_end = to1 ? t : r + HOLD;

    req_valid = 1'b1;
    req_op    = op;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k <= endk + 3; k++) begin
      bit low  = (k >= s) && (k < (to1 ? t : r));
      bit eoe  = !rd && (k < drv_end);
      bit erd  = rd ? 1'b1 : !(k < drv_end);
      bit ebsy = (k < endk);
      bit edn  = !to1 && !to2 && (k == l);
      bit eer  = (to1 || to2) && (k >= t);
      string etag = (k < s) ? "R4" : ((k > s + 2 && stray) ? "R2" : "R6");
      chk(seld ? "R5" : "R3", "addr_stb_n", addr_stb_n, !(low && !seld));
      chk(seld ? "R3" : "R5", "data_stb_n", data_stb_n, !(low && seld));
      chk(rd ? "R7" : etag, "link_rd", link_rd, erd);
      chk(rd ? "R7" : etag, "link_doe", link_doe, eoe);
      if (eoe) chk(etag, "link_dout", link_dout, wd);
      chk(to1 ? "R9" : (to2 ? "R10" : "R8"), "busy", busy, ebsy);
      chk("R8", "done", done, edn);
      chk((k < 1) ? "R11" : (to1 ? "R9" : "R10"), "err", err, eer);
      if (rd && !to1 && k >= r) chk("R7", "rd_data", rd_data, rv);
      // R2: a request made mid-transfer must be ignored
      if (stray && k == s + 2) begin
        req_valid = 1'b1;
        req_op    = ~op;
        req_wdata = ~wd;
      end
      if (stray && k == s + 3) req_valid = 1'b0;
      // R7: change the read bus two edges before release; old value must be kept
      if (rd && !to1 && k == r - 2) link_din = ~rv;
      @(negedge clk);
    end
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: state during reset
    chk("R1", "addr_stb_n", addr_stb_n, 1);
    chk("R1", "data_stb_n", data_stb_n, 1);
    chk("R1", "link_rd", link_rd, 1);
    chk("R1", "link_doe", link_doe, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "err", err, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "link_doe after reset", link_doe, 0);

    // R3 R4 R5 R6: address write, early wait so the minimum width rules
    run_op(2'b00, 8'hA5, 8'h00, 1, 1, 0);
    // R5 R6 R8: data write, late wait rise and slow wait fall
    run_op(2'b01, 8'h3C, 8'h00, 15, 4, 0);
    // R2 R7: address read with a stray request mid-transfer
    run_op(2'b10, 8'h00, 8'h5A, 2, 2, 1);
    // R7 R8: data read, both answers exactly at the timeout boundary
    run_op(2'b11, 8'h00, 8'hC3, TMO - 2, TMO - 2, 0);
    // R9: wait rise one cycle too late
    run_op(2'b01, 8'h77, 8'h00, TMO - 1, 1, 0);
    // R10 R11: error clears on accept, then wait fall too late
    run_op(2'b00, 8'h81, 8'h00, 3, TMO - 1, 0);
    // R11: next good transfer after a timeout
    run_op(2'b11, 8'h00, 8'h96, 4, 1, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule